// File: doc/BRIEF.md
# Two-Wire Real-Time-Clock Bus Master

This block drives the clock and data wires of a two-wire serial bus that leads to a real-time-clock device. It replaces a software loop that would toggle general-purpose pins. The engine reproduces that loop's waveform one phase at a time. A phase is one update of the four line controls: clock enable, clock level, data enable and data level. Every phase lasts a fixed number of system clocks, set by a parameter. The default suits roughly 2 µs at 250 MHz.

A host issues one command at a time through a valid/ready handshake. The commands are:
- return the lines to idle;
- open a transfer with a write or read device address;
- send a run of data bytes and close with a stop;
- receive a run of data bytes and close with a stop.

Bytes to send are taken from an input port, and a strobe asks for the next one. Received bytes appear on an output with a one-cycle valid strobe. A one-cycle `done` pulse marks the end of each command.

The engine never stretches the clock, never arbitrates and never examines the device's acknowledge bit. It still clocks every acknowledge slot.

Top module: `rtc_bus_master`

## Requirements
- R1: After reset all four line controls are high: clock enabled and high, data enabled and high. In the same state `busy` is 0, `cmd_ready` is 1 and `done` is 0.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `busy` is high from the next cycle. Each phase of the command holds its line values for exactly `HOLD_CYCLES` clocks.
- R3: Code 0 (and the unused codes 5 to 7) produces one phase, with both lines enabled and high.
- R4: Codes 1 (write) and 2 (read) open a transfer, in this order:
  - one phase with data low and clock high, then one with data low and clock low;
  - the address byte, 0xD0 for code 1 or 0xD1 for code 2, most significant bit first. Each bit takes three phases with data driven to the bit: clock low, clock high, clock low;
  - after every byte, an acknowledge slot with data released: clock low, then clock high;
  - code 1 then sends `cmd_word` in the same way, with its own acknowledge slot;
  - a final phase with data released and clock low.
  A released data line has enable 0 and level 0.
- R5: Code 3 sends `cmd_count` bytes, most significant bit first. Each bit takes three phases with data driven to the bit: clock low, high, high. After each byte comes an acknowledge slot with data released: clock low, high, low.
- R6: Code 4 receives `cmd_count` bytes. Each bit takes two phases with data released: clock low, then clock high. The data input is sampled as the clock-high phase ends, and bits are shifted in most significant first. `rd_valid` pulses one cycle after the eighth bit is sampled, with the byte on `rd_byte`.
- R7: After each received byte the master drives data low with the clock low. It then raises the clock with data low for every byte except the last. With the last byte it raises the clock with data high.
- R8: Codes 3 and 4 end with a stop of three phases: data low and clock low, data low and clock high, then data high and clock high. Data never changes while the clock stays high, except inside an opening sequence, a stop or an idle command.
- R9: `done` is high for exactly one cycle, in the first cycle after the last phase ends. In that cycle `busy` is 0 and `cmd_ready` is 1. The lines keep the last phase's values until the next command.
- R10: For code 3, `wr_byte` is captured when the command is accepted and again at the end of each acknowledge slot that is followed by another byte. `wr_taken` pulses in the cycle after each capture, so it pulses `cmd_count` times.
- R11: A `cmd_valid` pulse while `busy` is high is ignored. The running command's phase sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_code | input | 3 | 0 idle, 1 open-write, 2 open-read, 3 send, 4 receive |
| cmd_count | input | CNT_W | Byte count for send/receive, 1 to MAX_BYTES |
| cmd_word | input | 8 | Word address sent after the write device address |
| wr_byte | input | 8 | Byte to send |
| wr_taken | output | 1 | Pulse: current `wr_byte` captured, present the next |
| rd_byte | output | 8 | Received byte |
| rd_valid | output | 1 | Pulse: `rd_byte` holds a new byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at command end |
| scl_oe | output | 1 | Clock line drive enable |
| scl_out | output | 1 | Clock line level |
| sda_oe | output | 1 | Data line drive enable |
| sda_out | output | 1 | Data line level |
| sda_in | input | 1 | Sampled data line |

## Verification
The bench goes after the phase sequences that differ only by one phase.

- A data-write bit ends with the clock high, while an address bit ends with it low. A design that mixed the two would leave the clock in the wrong state and fail the phase-by-phase comparison.
- In a receive, only the last byte gets a not-acknowledge. An engine that did this on every byte, or never, shows a wrong data level on the last clock-high phase.
- A design that repeated the opening sequence per byte, or skipped the word address, leaves the expected-phase queue non-empty or overruns it.
- An engine that restarted on a `cmd_valid` pulse while busy shows extra phases.
- Sampling on the wrong phase shifts the received bytes by one bit.

// File: rtl/rtcbus_pkg.sv
package rtcbus_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE_LINES = 3'd0,
        CMD_OPEN_WR    = 3'd1,
        CMD_OPEN_RD    = 3'd2,
        CMD_SEND       = 3'd3,
        CMD_RECV       = 3'd4
    } cmd_e;

    localparam logic [7:0] DEV_WR = 8'hD0;
    localparam logic [7:0] DEV_RD = 8'hD1;

    typedef enum logic [3:0] {
        SG_IDLE, SG_INIT, SG_SCOND, SG_ABIT, SG_AACK, SG_AEND,
        SG_WBIT, SG_WACK, SG_RBIT, SG_RACK, SG_STOP
    } seg_e;

    typedef struct packed {
        logic clk_oe;
        logic clk;
        logic dat_oe;
        logic dat;
    } lines_t;

    localparam lines_t LINES_IDLE = '{clk_oe: 1'b1, clk: 1'b1, dat_oe: 1'b1, dat: 1'b1};

    // Line values of one phase, given segment, sub-phase, bit to send and the
    // not-acknowledge flag of a receive acknowledge slot.
    function automatic lines_t phase_lines(seg_e s, logic [1:0] sub, logic txb, logic nack);
        lines_t l;
        l = '{clk_oe: 1'b1, clk: 1'b0, dat_oe: 1'b0, dat: 1'b0};
        case (s)
            SG_SCOND: begin l.dat_oe = 1'b1; l.clk = (sub == 2'd0); end
            SG_ABIT:  begin l.dat_oe = 1'b1; l.dat = txb; l.clk = (sub == 2'd1); end
            SG_AACK, SG_WACK, SG_RBIT: l.clk = (sub == 2'd1);
            SG_AEND:  l.clk = 1'b0;
            SG_WBIT:  begin l.dat_oe = 1'b1; l.dat = txb; l.clk = (sub != 2'd0); end
            SG_RACK:  begin l.dat_oe = 1'b1; l.clk = (sub == 2'd1); l.dat = (sub == 2'd1) && nack; end
            SG_STOP:  begin l.dat_oe = 1'b1; l.clk = (sub != 2'd0); l.dat = (sub == 2'd2); end
            default:  l = LINES_IDLE;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/rtcbus_phase_timer.sv
module rtcbus_phase_timer #(
    parameter int HOLD_CYCLES = 500,
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expire
);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign expire = (cnt_q == LAST);

    // R2: the hold counter never passes the last cycle of a phase
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST);
endmodule

// File: rtl/rtcbus_shifter.sv
module rtcbus_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sample,
    input  logic         sdi,
    output logic         tx_next_msb,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load)       tx_q <= load_val;
            else if (shift) tx_q <= {tx_q[W-2:0], 1'b0};
            if (sample)     rx_q <= rx_word;
        end
    end

    assign tx_next_msb = load ? load_val[W-1] : (shift ? tx_q[W-2] : tx_q[W-1]);
    assign rx_word     = {rx_q[W-2:0], sdi};
endmodule

// File: rtl/rtc_bus_master.sv
module rtc_bus_master
    import rtcbus_pkg::*;
#(
    parameter int HOLD_CYCLES = 500,
    parameter int MAX_BYTES   = 8,
    localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_code,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic [7:0]       cmd_word,
    input  logic [7:0]       wr_byte,
    output logic             wr_taken,
    output logic [7:0]       rd_byte,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             scl_oe,
    output logic             scl_out,
    output logic             sda_oe,
    output logic             sda_out,
    input  logic             sda_in
);
    seg_e             seg_q, n_seg;
    logic [1:0]       sub_q, n_sub;
    logic [2:0]       bit_q, n_bit;
    logic [CNT_W-1:0] left_q, n_left;
    logic [7:0]       word_q, rx_word, load_val;
    lines_t           line_q;
    logic busy_q, done_q, taken_q, rdv_q;
    logic [7:0] rd_q;
    logic accept, phase_end, expire, adv, finish, take, emit;
    logic load_tx, shift_tx, sample, tx_next_msb;

    assign accept    = cmd_valid && !busy_q;
    assign phase_end = busy_q && expire;

    rtcbus_phase_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .restart(adv), .expire(expire)
    );

    rtcbus_shifter #(.W(8)) u_shift (
        .clk(clk), .rst(rst), .load(load_tx), .load_val(load_val), .shift(shift_tx),
        .sample(sample), .sdi(sda_in), .tx_next_msb(tx_next_msb), .rx_word(rx_word)
    );

    always_comb begin
        n_seg = seg_q; n_sub = sub_q; n_bit = bit_q; n_left = left_q;
        adv = 1'b0; finish = 1'b0; take = 1'b0; emit = 1'b0;
        load_tx = 1'b0; shift_tx = 1'b0; sample = 1'b0; load_val = wr_byte;
        if (accept) begin
            adv = 1'b1; n_sub = 2'd0; n_bit = 3'd0; n_left = cmd_count;
            case (cmd_e'(cmd_code))
                CMD_OPEN_WR: begin n_seg = SG_SCOND; load_tx = 1'b1; load_val = DEV_WR; n_left = CNT_W'(2); end
                CMD_OPEN_RD: begin n_seg = SG_SCOND; load_tx = 1'b1; load_val = DEV_RD; n_left = CNT_W'(1); end
                CMD_SEND:    begin n_seg = SG_WBIT; load_tx = 1'b1; take = 1'b1; end
                CMD_RECV:    n_seg = SG_RBIT;
                default:     n_seg = SG_INIT;
            endcase
        end else if (phase_end) begin
            adv = 1'b1;
            case (seg_q)
                SG_SCOND: if (sub_q == 2'd0) n_sub = 2'd1;
                          else begin n_seg = SG_ABIT; n_sub = 2'd0; n_bit = 3'd0; end
                SG_ABIT, SG_WBIT:
                    if (sub_q != 2'd2) n_sub = sub_q + 2'd1;
                    else if (bit_q != 3'd7) begin n_bit = bit_q + 3'd1; n_sub = 2'd0; shift_tx = 1'b1; end
                    else begin n_seg = (seg_q == SG_ABIT) ? SG_AACK : SG_WACK; n_sub = 2'd0; end
                SG_AACK:
                    if (sub_q == 2'd0) n_sub = 2'd1;
                    else if (left_q > CNT_W'(1)) begin
                        n_left = left_q - 1'b1; n_seg = SG_ABIT; n_sub = 2'd0; n_bit = 3'd0;
                        load_tx = 1'b1; load_val = word_q;
                    end else n_seg = SG_AEND;
                SG_WACK:
                    if (sub_q != 2'd2) n_sub = sub_q + 2'd1;
                    else if (left_q > CNT_W'(1)) begin
                        n_left = left_q - 1'b1; n_seg = SG_WBIT; n_sub = 2'd0; n_bit = 3'd0;
                        load_tx = 1'b1; take = 1'b1;
                    end else begin n_seg = SG_STOP; n_sub = 2'd0; end
                SG_RBIT:
                    if (sub_q == 2'd0) n_sub = 2'd1;
                    else begin
                        sample = 1'b1; n_sub = 2'd0;
                        if (bit_q != 3'd7) n_bit = bit_q + 3'd1;
                        else begin emit = 1'b1; n_seg = SG_RACK; end
                    end
                SG_RACK:
                    if (sub_q == 2'd0) n_sub = 2'd1;
                    else if (left_q > CNT_W'(1)) begin
                        n_left = left_q - 1'b1; n_seg = SG_RBIT; n_sub = 2'd0; n_bit = 3'd0;
                    end else begin n_seg = SG_STOP; n_sub = 2'd0; end
                SG_STOP:
                    if (sub_q != 2'd2) n_sub = sub_q + 2'd1;
                    else finish = 1'b1;
                default: finish = 1'b1;
            endcase
            if (finish) n_seg = SG_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= SG_IDLE; sub_q <= '0; bit_q <= '0; left_q <= '0; word_q <= '0;
            line_q <= LINES_IDLE; busy_q <= 1'b0; done_q <= 1'b0;
            taken_q <= 1'b0; rdv_q <= 1'b0; rd_q <= '0;
        end else begin
            done_q  <= finish;
            taken_q <= take;
            rdv_q   <= emit;
            if (emit)   rd_q   <= rx_word;
            if (accept) word_q <= cmd_word;
            if (adv) begin
                seg_q <= n_seg; sub_q <= n_sub; bit_q <= n_bit; left_q <= n_left;
                if (!finish) line_q <= phase_lines(n_seg, n_sub, tx_next_msb, n_left <= CNT_W'(1));
            end
            if (accept)      busy_q <= 1'b1;
            else if (finish) busy_q <= 1'b0;
        end
    end

    assign cmd_ready = !busy_q;
    assign busy      = busy_q;
    assign done      = done_q;
    assign wr_taken  = taken_q;
    assign rd_valid  = rdv_q;
    assign rd_byte   = rd_q;
    assign scl_oe    = line_q.clk_oe;
    assign scl_out   = line_q.clk;
    assign sda_oe    = line_q.dat_oe;
    assign sda_out   = line_q.dat;

    // R2: lines change only at a phase boundary chosen by the sequencer
    a_r2_change_on_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_q) |-> $past(adv));
    // R8: driven data is steady while the clock stays high, outside open/stop/idle
    a_r8_dat_steady_clk_high: assert property (@(posedge clk) disable iff (rst)
        (line_q.clk && $past(line_q.clk) && line_q.dat_oe && $past(line_q.dat_oe)
         && (line_q.dat != $past(line_q.dat)))
        |-> (seg_q == SG_SCOND || seg_q == SG_STOP || seg_q == SG_INIT));
    // R9: done is a single-cycle pulse seen with the engine free
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy_q ##1 !done_q));
    // R6: a received byte is only presented straight after a read bit
    a_r6_rd_after_bit: assert property (@(posedge clk) disable iff (rst)
        rdv_q |-> $past(seg_q == SG_RBIT));
    // R10: the byte request only pulses while data bits are going out
    a_r10_take_in_send: assert property (@(posedge clk) disable iff (rst)
        taken_q |-> (busy_q && seg_q == SG_WBIT));
endmodule

// File: tb/rtc_bus_master_tb.sv
module rtc_bus_master_tb;
    localparam int HOLD = 4;
    localparam int MAXB = 8;
    localparam int CW   = $clog2(MAXB + 1);

    logic clk = 1'b0, rst = 1'b1;
    always #2 clk = ~clk;

    logic cmd_valid = 1'b0, cmd_ready;
    logic [2:0] cmd_code = '0;
    logic [CW-1:0] cmd_count = '0;
    logic [7:0] cmd_word = '0, wr_byte = '0, rd_byte;
    logic wr_taken, rd_valid, busy, done;
    logic scl_oe, scl_out, sda_oe, sda_out, sda_in = 1'b1;

    rtc_bus_master #(.HOLD_CYCLES(HOLD), .MAX_BYTES(MAXB)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_count(cmd_count), .cmd_word(cmd_word),
        .wr_byte(wr_byte), .wr_taken(wr_taken), .rd_byte(rd_byte), .rd_valid(rd_valid),
        .busy(busy), .done(done), .scl_oe(scl_oe), .scl_out(scl_out),
        .sda_oe(sda_oe), .sda_out(sda_out), .sda_in(sda_in)
    );

    int checks = 0, fails = 0;
    logic [3:0] exp_q[$];
    logic [7:0] rdexp_q[$];
    logic [3:0] cur = 4'hF;
    string cur_req = "R1";
    int pc = 0, widx = 0, takes = 0, rises = 0;
    logic [7:0] wsrc[8];
    logic [7:0] slv[8];
    logic reading = 1'b0, prev_scl = 1'b1;

    function automatic logic [3:0] lines();
        return {scl_oe, scl_out, sda_oe, sda_out};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ph(input logic c, input logic doe, input logic d);
        exp_q.push_back({1'b1, c, doe, d});
    endtask

    task automatic exp_byte_addr(input logic [7:0] b);
        for (int j = 7; j >= 0; j--) begin ph(0, 1, b[j]); ph(1, 1, b[j]); ph(0, 1, b[j]); end
        ph(0, 0, 0); ph(1, 0, 0);
    endtask

    task automatic exp_stop();
        ph(0, 1, 0); ph(1, 1, 0); ph(1, 1, 1);
    endtask

    task automatic exp_open(input bit wr, input logic [7:0] word);
        ph(1, 1, 0); ph(0, 1, 0);
        exp_byte_addr(wr ? 8'hD0 : 8'hD1);
        if (wr) exp_byte_addr(word);
        ph(0, 0, 0);
    endtask

    task automatic exp_send(input int n);
        for (int k = 0; k < n; k++) begin
            for (int j = 7; j >= 0; j--) begin ph(0, 1, wsrc[k][j]); ph(1, 1, wsrc[k][j]); ph(1, 1, wsrc[k][j]); end
            ph(0, 0, 0); ph(1, 0, 0); ph(0, 0, 0);
        end
        exp_stop();
    endtask

    task automatic exp_recv(input int n);
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < 8; j++) begin ph(0, 0, 0); ph(1, 0, 0); end
            ph(0, 1, 0); ph(1, 1, (k == n - 1));
            rdexp_q.push_back(slv[k]);
        end
        exp_stop();
    endtask

    // Monitor: pops one expected phase per HOLD cycles while busy
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) begin
                if (pc == 0) begin
                    if (exp_q.size() == 0) begin
                        check(0, {cur_req, " extra phase"}, lines(), 0);
                        cur = lines();
                    end else cur = exp_q.pop_front();
                end
                if (pc == 0 || pc == HOLD - 1) check(lines() == cur, {cur_req, " phase lines"}, lines(), cur);
                pc = (pc == HOLD - 1) ? 0 : pc + 1;
            end else pc = 0;
            if (rd_valid) begin
                if (rdexp_q.size() == 0) check(0, "R6 extra byte", rd_byte, 0);
                else begin
                    logic [7:0] e;
                    e = rdexp_q.pop_front();
                    check(rd_byte == e, "R6 received byte", rd_byte, e);
                end
            end
            if (wr_taken) begin
                takes++;
                widx++;
                wr_byte = wsrc[widx % 8];
            end
            if (reading && scl_out && !prev_scl) begin
                if (rises % 9 < 8) sda_in = slv[(rises / 9) % 8][7 - (rises % 9)];
                else sda_in = 1'b1;
                rises++;
            end
            prev_scl = scl_out;
        end
    end

    task automatic do_cmd(input logic [2:0] code, input int n, input logic [7:0] word,
                          input string req, input bit poke);
        cur_req = req;
        widx = 0; takes = 0; rises = 0;
        wr_byte = wsrc[0];
        reading = (code == 3'd4);
        @(negedge clk);
        check(cmd_ready == 1'b1, "R9 ready before command", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_code = code; cmd_count = CW'(n); cmd_word = word;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", busy, 1);
        if (poke) begin
            repeat (10) @(negedge clk);
            cmd_valid = 1'b1; cmd_code = 3'd4; cmd_count = CW'(1);  // R11 ignored while busy
            @(negedge clk);
            cmd_valid = 1'b0;
            check(busy == 1'b1, "R11 still busy", busy, 1);
        end
        while (!done) @(negedge clk);
        check(busy == 1'b0 && cmd_ready == 1'b1, "R9 free at done", {busy, cmd_ready}, 2'b01);
        check(exp_q.size() == 0, {req, " phase count"}, exp_q.size(), 0);
        if (code == 3'd4) check(rdexp_q.size() == 0, "R6 all bytes", rdexp_q.size(), 0);
        if (code == 3'd3) check(takes == n, "R10 take count", takes, n);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", done, 0);
        repeat (3) @(negedge clk);
        check(lines() == cur, "R9 lines held", lines(), cur);
        reading = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(lines() == 4'hF, "R1 lines at reset", lines(), 4'hF);
        check(!busy && cmd_ready && !done, "R1 status at reset", {busy, cmd_ready, done}, 3'b010);
        rst = 1'b0;
        @(negedge clk);
        check(lines() == 4'hF, "R1 lines after reset", lines(), 4'hF);

        ph(1, 1, 1);
        do_cmd(3'd0, 1, 8'h00, "R3 idle", 0);

        exp_open(1, 8'h3A);
        do_cmd(3'd1, 1, 8'h3A, "R4 open write", 0);

        wsrc[0] = 8'hA5; wsrc[1] = 8'h01; wsrc[2] = 8'hFF;
        for (int i = 3; i < 8; i++) wsrc[i] = 8'h00;
        exp_send(3);
        do_cmd(3'd3, 3, 8'h00, "R5 send three with R8 stop", 1);

        exp_open(0, 8'h00);
        do_cmd(3'd2, 1, 8'h00, "R4 open read", 0);

        slv[0] = 8'h96;
        for (int i = 1; i < 8; i++) slv[i] = 8'h00;
        exp_recv(1);
        do_cmd(3'd4, 1, 8'h00, "R7 single byte nack", 0);

        for (int i = 0; i < 8; i++) slv[i] = 8'(8'h1D * i + 8'h81);
        slv[3] = 8'h00; slv[4] = 8'hFF;
        exp_recv(8);
        do_cmd(3'd4, 8, 8'h00, "R6 receive eight with R7 ack", 0);

        wsrc[0] = 8'h80;
        exp_send(1);
        do_cmd(3'd3, 1, 8'h00, "R5 send one", 0);

        ph(1, 1, 1);
        do_cmd(3'd7, 1, 8'h00, "R3 unused code", 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule